// File: doc/BRIEF.md
# Rehearsal-Learned Transition Automation Matrix

This block is a synchronous controller placed beside K memory-mapped action words. Each word reports completion with a single-cycle done pulse and is started by an enable output. A processor starts words through a request port, and each request reaches the matching enable in the same cycle. For every ordered pair of distinct words (i, j), the block watches for a request of word j that follows a done of word i within a short window. Each such event is one rehearsal of the pair.

Every pair counts its rehearsals in a set-only thermometer of N stages. When the last stage sets, the pair becomes a permanent link. From then on, each done of word i starts word j a fixed L cycles later with no processor request. Words that are linked in a row therefore run as a chain, and the chain ends at a word that has no linked successor. Separate chains run side by side without affecting each other. An inhibit input masks the automatic enables but keeps everything already learned. A clear input, or reset, removes all learning. The learned pairs can be read at any time as a K-by-K bitmap.

Top module: `rlm_matrix`

## Requirements
- R1: A request for word j counts as a rehearsal of pair (i, j) only if it comes in one of the W cycles that follow the cycle in which word i reported done. A request in the same cycle as the done does not count, and neither does one W+1 or more cycles later. The first counted request closes the window, so further requests in that window do not count. A new done of word i opens a fresh window.
- R2: Each rehearsal advances the pair's count by exactly one stage. Only processor requests count as rehearsals. An enable produced by a learned link never advances any count.
- R3: A pair becomes learned on its N-th rehearsal and no earlier. Bit i*K+j of `learned_map` goes high in the cycle after that rehearsal and stays high until clear or reset.
- R4: If pair (i, j) is learned in the cycle in which word i reports done (cycle c), `word_en[j]` is high for one cycle in cycle c+L, with no request.
- R5: Automatic enables carry on from word to word along learned links and stop at a word that has no learned successor. Chains started in the same cycle run independently.
- R6: A word can never be linked to itself. Bit i*K+i of `learned_map` is always 0, however often word i is requested after its own done.
- R7: While `inhibit` is high, `word_en` equals `cpu_req`. Learned links are kept while inhibit is high.
- R8: A `clear` in cycle c empties all learning, open windows and pending automatic enables. From cycle c+1, `learned_map` is 0, no enable that was pending appears, and a request that falls inside a window opened before the clear does not count.
- R9: `word_en` is the OR of `cpu_req` in the same cycle and the automatic enables that are due.
- R10: During reset and after it, `learned_map` is 0 and `word_en` equals `cpu_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; removes all learning |
| clear | input | 1 | Synchronous unlearn of all pairs, windows and pending triggers |
| inhibit | input | 1 | Masks all automatic enables while high |
| cpu_req | input | K | Processor request, one bit per word |
| word_done | input | K | Single-cycle done pulse from each word |
| word_en | output | K | Enable to each word |
| learned_map | output | K*K | Learned pairs; bit i*K+j means word i triggers word j |

## Verification
The embedded properties assume that `clear` and `inhibit` change only between clock edges and that reset is released synchronously. They do not depend on how requests and done pulses are spaced. A property that ties an automatic enable to a learned link relies on the pipeline being flushed at the same time as the learning is removed. The stimulus drives all inputs half a cycle away from the active edge. A word responder returns done one cycle after each enable, and rehearsals are spaced so that only the intended window is open when each request arrives. The stimulus never teaches a cycle of links between several words, so every chain it starts comes to an end.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

   // Flat position of the link from a source word to a destination word
   function automatic int link_pos(input int src, input int dst, input int words);
      return src * words + dst;
   endfunction

endpackage

// File: rtl/rlm_pair_det.sv
module rlm_pair_det #(
   parameter int N = 3,
   parameter int W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic src_done,
   input  logic dst_req,
   output logic learned
);

   localparam int TW = (W < 2) ? 1 : $clog2(W + 1);

   generate
      if (N < 1) begin : g_bad_n
         $error("rlm_pair_det: N must be at least 1");
      end
      if (W < 1) begin : g_bad_w
         $error("rlm_pair_det: W must be at least 1");
      end
   endgenerate

   logic [TW-1:0] timer_q;
   logic [N-1:0]  stage_q;
   logic [N-1:0]  stage_nx;
   logic          armed;
   logic          hit;

   assign armed = (timer_q != '0);
   assign hit   = armed & dst_req;

   // thermometer advance: one more stage set per rehearsal
   generate
      if (N == 1) begin : g_single
         assign stage_nx = 1'b1;
      end else begin : g_chain
         assign stage_nx = {stage_q[N-2:0], 1'b1};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer_q <= '0;
         stage_q <= '0;
      end else if (clear) begin
         timer_q <= '0;
         stage_q <= '0;
      end else begin
         if (src_done) begin
            timer_q <= TW'(W);
         end else if (hit) begin
            timer_q <= '0;
         end else if (armed) begin
            timer_q <= timer_q - TW'(1);
         end
         if (hit) begin
            stage_q <= stage_nx;
         end
      end
   end

   assign learned = stage_q[N-1];

   // R3
   learned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (learned && !clear) |=> learned);

   // R2
   therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stage_q + N'(1)) & stage_q) == '0);

   // R2
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ($countones(stage_q) <= $countones($past(stage_q)) + 1));

   // R1
   window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !src_done && !clear) |=> (timer_q == '0));

endmodule

// File: rtl/rlm_route.sv
module rlm_route
   import rlm_pkg::*;
#(
   parameter int K = 4
) (
   input  logic [K-1:0]   done,
   input  logic [K*K-1:0] links,
   output logic [K-1:0]   targets
);

   generate
      if (K < 2) begin : g_bad_k
         $error("rlm_route: K must be at least 2");
      end
   endgenerate

   always_comb begin
      targets = '0;
      for (int d = 0; d < K; d++) begin
         for (int s = 0; s < K; s++) begin
            if (s != d) begin
               targets[d] = targets[d] | (done[s] & links[link_pos(s, d, K)]);
            end
         end
      end
   end

endmodule

// File: rtl/rlm_trig_pipe.sv
module rlm_trig_pipe #(
   parameter int K = 4,
   parameter int L = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic [K-1:0] tgt_in,
   output logic [K-1:0] tgt_out
);

   generate
      if (L < 1) begin : g_bad_l
         $error("rlm_trig_pipe: L must be at least 1");
      end

      if (L == 1) begin : g_one
         logic [K-1:0] stg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_q <= '0;
            end else if (flush) begin
               stg_q <= '0;
            end else begin
               stg_q <= tgt_in;
            end
         end
         assign tgt_out = stg_q;
      end else begin : g_many
         logic [K-1:0] stg_q [L];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < L; s++) stg_q[s] <= '0;
            end else if (flush) begin
               for (int s = 0; s < L; s++) stg_q[s] <= '0;
            end else begin
               stg_q[0] <= tgt_in;
               for (int s = 1; s < L; s++) stg_q[s] <= stg_q[s-1];
            end
         end
         assign tgt_out = stg_q[L-1];
      end
   endgenerate

   // R8
   flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (tgt_out == '0));

endmodule

// File: rtl/rlm_matrix.sv
module rlm_matrix
   import rlm_pkg::*;
#(
   parameter int K = 4,
   parameter int N = 3,
   parameter int W = 4,
   parameter int L = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           inhibit,
   input  logic [K-1:0]   cpu_req,
   input  logic [K-1:0]   word_done,
   output logic [K-1:0]   word_en,
   output logic [K*K-1:0] learned_map
);

   localparam int PAIRS = K * K;

   generate
      if (K < 2) begin : g_bad_k
         $error("rlm_matrix: K must be at least 2");
      end
      if (L < 1) begin : g_bad_l
         $error("rlm_matrix: L must be at least 1");
      end
   endgenerate

   logic [K-1:0]     tgt_now;
   logic [K-1:0]     tgt_due;
   logic [PAIRS-1:0] link_vec;

   generate
      for (genvar gs = 0; gs < K; gs++) begin : g_src
         for (genvar gd = 0; gd < K; gd++) begin : g_dst
            if (gs == gd) begin : g_diag
               assign link_vec[gs*K+gd] = 1'b0;
            end else begin : g_pair
               rlm_pair_det #(
                  .N (N),
                  .W (W)
               ) u_det (
                  .clk      (clk),
                  .rst_n    (rst_n),
                  .clear    (clear),
                  .src_done (word_done[gs]),
                  .dst_req  (cpu_req[gd]),
                  .learned  (link_vec[gs*K+gd])
               );
            end
         end
      end
   endgenerate

   rlm_route #(
      .K (K)
   ) u_route (
      .done    (word_done),
      .links   (link_vec),
      .targets (tgt_now)
   );

   rlm_trig_pipe #(
      .K (K),
      .L (L)
   ) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (clear),
      .tgt_in  (tgt_now),
      .tgt_out (tgt_due)
   );

   assign word_en     = cpu_req | (tgt_due & ~{K{inhibit}});
   assign learned_map = link_vec;

   // R8
   clear_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (learned_map == '0));

   // R7
   inhibit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |-> (word_en == cpu_req));

   // R5
   auto_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((word_en & ~cpu_req) != '0) |-> (learned_map != '0));

endmodule

// File: tb/rlm_matrix_tb_top.sv
`timescale 1ns/1ps
module rlm_matrix_tb_top;

   localparam int K = 4;
   localparam int N = 3;
   localparam int W = 4;
   localparam int L = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           clear = 1'b0;
   logic           inhibit = 1'b0;
   logic [K-1:0]   cpu_req = '0;
   logic [K-1:0]   word_done = '0;
   logic [K-1:0]   word_en;
   logic [K*K-1:0] learned_map;

   always #2.5 clk = ~clk;

   rlm_matrix #(.K(K), .N(N), .W(W), .L(L)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (clear),
      .inhibit     (inhibit),
      .cpu_req     (cpu_req),
      .word_done   (word_done),
      .word_en     (word_en),
      .learned_map (learned_map)
   );

   // ---------------- behavioural reference ----------------
   int           m_tmr [K][K];
   int           m_cnt [K][K];
   int           due_q [$];
   logic [K-1:0] vec_q [$];
   int           cyc = 0;

   function automatic logic [K-1:0] ref_auto();
      logic [K-1:0] acc;
      acc = '0;
      for (int q = 0; q < due_q.size(); q++)
         if (due_q[q] == cyc) acc = acc | vec_q[q];
      return acc;
   endfunction

   function automatic logic [K*K-1:0] ref_map();
      logic [K*K-1:0] m;
      m = '0;
      for (int s = 0; s < K; s++)
         for (int d = 0; d < K; d++)
            if (s != d && m_cnt[s][d] >= N) m[s*K+d] = 1'b1;
      return m;
   endfunction

   always @(posedge clk) begin
      logic [K-1:0] tg;
      logic         h;
      if (!rst_n || clear) begin
         for (int s = 0; s < K; s++)
            for (int d = 0; d < K; d++) begin
               m_tmr[s][d] = 0;
               m_cnt[s][d] = 0;
            end
         due_q.delete();
         vec_q.delete();
      end else begin
         tg = '0;
         for (int s = 0; s < K; s++)
            for (int d = 0; d < K; d++)
               if (s != d && m_cnt[s][d] >= N && word_done[s]) tg[d] = 1'b1;
         if (tg != '0) begin
            due_q.push_back(cyc + L);
            vec_q.push_back(tg);
         end
         for (int s = 0; s < K; s++)
            for (int d = 0; d < K; d++)
               if (s != d) begin
                  h = (m_tmr[s][d] > 0) && cpu_req[d];
                  if (h && m_cnt[s][d] < N) m_cnt[s][d]++;
                  if (word_done[s]) m_tmr[s][d] = W;
                  else if (h) m_tmr[s][d] = 0;
                  else if (m_tmr[s][d] > 0) m_tmr[s][d]--;
               end
      end
      cyc++;
      while (due_q.size() > 0 && due_q[0] < cyc) begin
         void'(due_q.pop_front());
         void'(vec_q.pop_front());
      end
   end

   // ---------------- stimulus and checking ----------------
   int           vecs = 0;
   int           errs = 0;
   bit           finished = 0;
   string        phase = "R10";
   logic [K-1:0] s_req = '0, s_done = '0, prev_en = '0, last_en = '0;
   logic         s_clr = 0, s_inh = 0, s_rst = 0, resp_on = 0;

   task automatic tick();
      logic [K-1:0]   exp_en;
      logic [K*K-1:0] exp_map;
      @(negedge clk);
      rst_n     = s_rst;
      clear     = s_clr;
      inhibit   = s_inh;
      cpu_req   = s_req;
      word_done = s_done | (resp_on ? prev_en : '0);
      #1;
      exp_en  = cpu_req | (ref_auto() & ~{K{inhibit}});
      exp_map = ref_map();
      vecs++;
      if (word_en !== exp_en || learned_map !== exp_map) begin
         errs++;
         $display("FAIL %s cycle %0d: enable act %b exp %b, map act %h exp %h",
                  phase, cyc, word_en, exp_en, learned_map, exp_map);
      end
      last_en = word_en;
      prev_en = word_en;
      s_req  = '0;
      s_done = '0;
      s_clr  = 0;
   endtask

   task automatic idle(input int n);
      for (int t = 0; t < n; t++) tick();
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: act %h exp %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
   endtask

   initial begin
      // R10 reset state
      s_rst = 0; s_req = 4'b1010; tick();
      chk(last_en == 4'b1010 && learned_map == '0, "R10 in reset", {last_en, learned_map}, {4'b1010, 16'h0});
      idle(2);
      s_rst = 1; s_req = 4'b1010; tick();
      chk(last_en == 4'b1010 && learned_map == '0, "R10 after reset", {last_en, learned_map}, {4'b1010, 16'h0});
      idle(3);

      // R1: requests outside the window or in the done cycle do not count (pair 2->3)
      phase = "R1";
      for (int r = 0; r < 3; r++) begin
         s_done = 4'b0100; tick();
         idle(W);
         s_req = 4'b1000; tick();
         idle(6);
      end
      s_done = 4'b0100; s_req = 4'b1000; tick();
      idle(6);
      chk(learned_map == '0, "R1 out-of-window", learned_map, 16'h0);
      // one window with two requests counts once, then one edge-of-window rehearsal
      s_done = 4'b0100; tick();
      s_req = 4'b1000; tick();
      s_req = 4'b1000; tick();
      idle(6);
      s_done = 4'b0100; tick();
      idle(W - 1);
      s_req = 4'b1000; tick();
      idle(6);
      phase = "R3";
      chk(learned_map == '0, "R3 two rehearsals", learned_map, 16'h0);
      s_done = 4'b0100; tick();
      s_req = 4'b1000; tick();
      tick();
      chk(learned_map == 16'h0800, "R3 third rehearsal", learned_map, 16'h0800);
      idle(6);

      // R2: automatic enable of word 3 inside pair 0->3 window never counts
      phase = "R2";
      for (int r = 0; r < 4; r++) begin
         s_done = 4'b0101; tick();
         tick();
         tick();
         chk(last_en == 4'b1000, "R4 auto enable after L", last_en, 4'b1000);
         idle(6);
      end
      chk(learned_map == 16'h0800, "R2 auto not rehearsal", learned_map, 16'h0800);

      // learn 0->1 and 1->2 through a responding word model
      phase = "R3";
      resp_on = 1;
      for (int r = 0; r < 3; r++) begin
         s_req = 4'b0001; tick();
         tick();
         s_req = 4'b0010; tick();
         idle(3);
         s_req = 4'b0100; tick();
         idle(12);
      end
      chk(learned_map == 16'h0842, "R3 two links learned", learned_map, 16'h0842);

      // R4/R5 chain 0->1->2->3 then stop
      phase = "R5";
      s_req = 4'b0001; tick();
      for (int t = 1; t <= 15; t++) begin
         tick();
         if (t == 3)  chk(last_en == 4'b0010, "R4 chain step 1", last_en, 4'b0010);
         if (t == 6)  chk(last_en == 4'b0100, "R5 chain step 2", last_en, 4'b0100);
         if (t == 9)  chk(last_en == 4'b1000, "R5 chain step 3", last_en, 4'b1000);
         if (t >= 10) chk(last_en == 4'b0000, "R5 chain stops", last_en, 4'b0000);
      end
      resp_on = 0;
      idle(4);

      // R5 parallel chains started together
      s_done = 4'b0011; tick();
      tick();
      tick();
      chk(last_en == 4'b0110, "R5 parallel", last_en, 4'b0110);
      idle(6);

      // R7 inhibit masks automatic enables, keeps links
      phase = "R7";
      s_inh = 1; resp_on = 1;
      s_req = 4'b0001; tick();
      tick();
      tick();
      tick();
      chk(last_en == 4'b0000, "R7 masked", last_en, 4'b0000);
      idle(6);
      chk(learned_map == 16'h0842, "R7 links kept", learned_map, 16'h0842);
      s_inh = 0; resp_on = 0;
      idle(3);

      // R8 clear drops pending enable and links
      phase = "R8";
      s_done = 4'b0001; tick();
      s_clr = 1; tick();
      tick();
      chk(last_en == 4'b0000 && learned_map == '0, "R8 cleared", {last_en, learned_map}, {4'b0000, 16'h0});
      idle(4);
      s_done = 4'b0100; tick();
      s_clr = 1; tick();
      s_req = 4'b1000; tick();
      idle(6);
      for (int r = 0; r < 2; r++) begin
         s_done = 4'b0100; tick();
         s_req = 4'b1000; tick();
         idle(6);
      end
      chk(learned_map == '0, "R8 stale window ignored", learned_map, 16'h0);
      phase = "R3";
      s_done = 4'b0100; tick();
      s_req = 4'b1000; tick();
      tick();
      chk(learned_map == 16'h0800, "R3 relearn", learned_map, 16'h0800);
      idle(6);

      // R6 self pair never learned
      phase = "R6";
      for (int r = 0; r < 4; r++) begin
         s_done = 4'b0010; tick();
         s_req = 4'b0010; tick();
         idle(6);
      end
      chk(learned_map[5] == 1'b0 && learned_map == 16'h0800, "R6 no self link", learned_map, 16'h0800);

      // R9 same-cycle request path
      phase = "R9";
      s_req = 4'b0101; tick();
      chk(last_en == 4'b0101, "R9 request passthrough", last_en, 4'b0101);
      idle(4);

      finished = 1;
      summary();
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         errs++;
         $display("FAIL watchdog: act running exp finished");
         summary();
         $finish;
      end
   end

endmodule